// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit RISC core fetches next. It takes the current program counter, a control class from the decoder and all the operands that class needs. From these it forms the next program counter and a taken flag. When the class calls for a link, it also forms a link value and a request to write it to the return-address register. The decoder and the fetch stage sit on either side of it.

It handles four kinds of flow change:
- Sequential flow.
- Conditional branches. These compare two register values and add a scaled, sign-extended word offset to the address of the following instruction.
- Absolute jumps. These keep the top four bits of the following instruction's address, so the target stays within a 256 MB region.
- Jumps through a register.

The call form writes the return address, then jumps like an absolute jump.

All results are registered once in the two-process style. A class presented at one clock edge shows its result at the outputs after that edge. Reset loads a programmable start address.

Top module: `npc_unit`

## Requirements
- R1: Control class encoding on `ctl_class`: 0 = sequential, 1 = branch if equal, 2 = branch if not equal, 3 = jump, 4 = jump and link, 5 = jump through register. Codes 6 and 7 act as sequential. For sequential flow, `next_pc` is `cur_pc` + 4 and `taken` is 0.
- R2: Class 1 is taken only when `cmp_a` equals `cmp_b` in all 32 bits. Class 2 is taken only when they differ. A branch that is not taken gives `cur_pc` + 4.
- R3: A taken branch gives (`cur_pc` + 4) + (sign-extended `br_offset` << 2), modulo 2^32. Offsets 0x7FFF and 0x8000 reach the forward and backward limits.
- R4: Classes 3 and 4 give {(`cur_pc` + 4)[31:28], `jmp_field`, 2'b00}. A field of 2500 from a low address gives byte address 10000.
- R5: Class 5 gives `jr_value` unchanged, with no alignment forcing.
- R6: `taken` is 1 for classes 3, 4 and 5, and for a branch whose condition holds. Otherwise it is 0.
- R7: For class 4 only, `link_we` is 1 and `link_value` is `cur_pc` + 4. `link_reg` is always 31. For every other class, `link_we` is 0.
- R8: Results appear at the outputs one clock after the inputs are sampled at a rising edge.
- R9: While `rst_n` is low, `next_pc` is RESET_PC (0 by default), and `taken`, `link_we` and `link_value` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc | input | 32 | Address of the current instruction |
| ctl_class | input | 3 | Decoded control class (encoding in R1) |
| cmp_a | input | 32 | First compared register value |
| cmp_b | input | 32 | Second compared register value |
| br_offset | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Word target field of an absolute jump |
| jr_value | input | 32 | Register value for a register jump |
| next_pc | output | 32 | Registered next program counter |
| taken | output | 1 | Registered flow-change flag |
| link_we | output | 1 | Registered link write request |
| link_reg | output | 5 | Link destination register index (31) |
| link_value | output | 32 | Registered return address |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produce it: `next_pc`, `taken`, `link_we` and `link_value` all pass through the same single register stage. The bench drives each stimulus just after a falling edge. It then waits for the next falling edge, which puts exactly one rising edge between stimulus and sample, and compares there. Reset values are sampled while reset is held low. A sequential class that follows a call is checked at the next sample, which shows the link request going back to 0.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN        = 32;
    localparam int OFS_W       = 16;
    localparam int FIELD_W     = 26;
    localparam int REG_IDX_W   = 5;
    localparam int INSN_BYTES  = 4;
    localparam int ALIGN_BITS  = $clog2(INSN_BYTES);
    localparam int REGION_BITS = XLEN - FIELD_W - ALIGN_BITS;

    typedef enum logic [2:0] {
        CLS_SEQ  = 3'd0,
        CLS_BEQ  = 3'd1,
        CLS_BNE  = 3'd2,
        CLS_JMP  = 3'd3,
        CLS_JAL  = 3'd4,
        CLS_JREG = 3'd5
    } ctl_class_e;

    typedef struct packed {
        logic [XLEN-1:0] next_pc;
        logic            taken;
        logic            link_we;
        logic [XLEN-1:0] link_value;
    } npc_state_t;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [2:0]   cls,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         is_branch,
    output logic         cond_true
);
    logic same;

    always_comb begin
        same      = (op_a == op_b);
        is_branch = (cls == CLS_BEQ) || (cls == CLS_BNE);
        unique case (cls)
            CLS_BEQ: cond_true = same;
            CLS_BNE: cond_true = !same;
            default: cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int OW   = OFS_W,
    parameter int FW   = FIELD_W,
    parameter int AB   = ALIGN_BITS
) (
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] offset,
    input  logic [FW-1:0] field,
    output logic [W-1:0]  seq_pc,
    output logic [W-1:0]  br_pc,
    output logic [W-1:0]  jmp_pc
);
    localparam int RB  = W - FW - AB;
    localparam int EXT = W - OW - AB;

    logic [W-1:0] scaled_ofs;

    always_comb begin
        seq_pc     = pc + W'(1 << AB);
        scaled_ofs = {{EXT{offset[OW-1]}}, offset, {AB{1'b0}}};
        br_pc      = seq_pc + scaled_ofs;
        jmp_pc     = {seq_pc[W-1 -: RB], field, {AB{1'b0}}};
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              LINK_IDX = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic [2:0]           ctl_class,
    input  logic [XLEN-1:0]      cmp_a,
    input  logic [XLEN-1:0]      cmp_b,
    input  logic [OFS_W-1:0]     br_offset,
    input  logic [FIELD_W-1:0]   jmp_field,
    input  logic [XLEN-1:0]      jr_value,
    output logic [XLEN-1:0]      next_pc,
    output logic                 taken,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_reg,
    output logic [XLEN-1:0]      link_value
);
    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
    logic            is_branch, cond_true;
    npc_state_t      state_d, state_q;

    npc_cond #(.W(XLEN)) u_cond (
        .cls       (ctl_class),
        .op_a      (cmp_a),
        .op_b      (cmp_b),
        .is_branch (is_branch),
        .cond_true (cond_true)
    );

    npc_targets #(.W(XLEN), .OW(OFS_W), .FW(FIELD_W), .AB(ALIGN_BITS)) u_tgt (
        .pc     (cur_pc),
        .offset (br_offset),
        .field  (jmp_field),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc)
    );

    always_comb begin
        state_d            = '0;
        state_d.next_pc    = seq_pc;
        state_d.link_value = '0;
        unique case (ctl_class)
            CLS_BEQ, CLS_BNE: begin
                if (is_branch && cond_true) begin
                    state_d.next_pc = br_pc;
                    state_d.taken   = 1'b1;
                end
            end
            CLS_JMP: begin
                state_d.next_pc = jmp_pc;
                state_d.taken   = 1'b1;
            end
            CLS_JAL: begin
                state_d.next_pc    = jmp_pc;
                state_d.taken      = 1'b1;
                state_d.link_we    = 1'b1;
                state_d.link_value = seq_pc;
            end
            CLS_JREG: begin
                state_d.next_pc = jr_value;
                state_d.taken   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.next_pc <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    assign next_pc    = state_q.next_pc;
    assign taken      = state_q.taken;
    assign link_we    = state_q.link_we;
    assign link_value = state_q.link_value;
    assign link_reg   = REG_IDX_W'(LINK_IDX);

    // Checker support: high once a registered result reflects sampled inputs.
    logic live_d, live_q;
    always_comb live_d = 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= live_d;
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(ctl_class) == CLS_SEQ) |->
            (next_pc == $past(cur_pc) + 32'd4) && !taken); // R1

    AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(ctl_class) == CLS_BEQ) && ($past(cmp_a) != $past(cmp_b)) |->
            !taken && (next_pc == $past(cur_pc) + 32'd4)); // R2

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && (($past(ctl_class) == CLS_JMP) || ($past(ctl_class) == CLS_JAL)) |->
            (next_pc[XLEN-1 -: REGION_BITS] == ($past(cur_pc) + 32'd4) >> (XLEN - REGION_BITS))
            && (next_pc[1:0] == 2'b00)); // R4

    AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(ctl_class) == CLS_JREG) |-> taken && (next_pc == $past(jr_value))); // R5

    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && link_we |-> ($past(ctl_class) == CLS_JAL)
            && (link_value == $past(cur_pc) + 32'd4) && taken); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !taken && !link_we && (next_pc == RESET_PC)); // R9

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
    import npc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, cmp_a = '0, cmp_b = '0, jr_value = '0;
    logic [2:0]  ctl_class = 3'd0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] next_pc, link_value;
    logic        taken, link_we;
    logic [4:0]  link_reg;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    npc_unit uut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .ctl_class(ctl_class),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .br_offset(br_offset), .jmp_field(jmp_field),
        .jr_value(jr_value), .next_pc(next_pc), .taken(taken), .link_we(link_we),
        .link_reg(link_reg), .link_value(link_value)
    );

    typedef struct packed {
        logic [2:0]  cls;
        logic [31:0] pc;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] ofs;
        logic [25:0] fld;
        logic [31:0] jr;
        logic [31:0] exp_pc;
        logic        exp_tk;
        logic        exp_lk;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_1000, 32'd0, 32'd0, 16'h0000, 26'h0, 32'h0, 32'h0000_1004, 1'b0, 1'b0}, // R1 sequential
        '{3'd1, 32'h0000_1000, 32'd5, 32'd5, 16'h0010, 26'h0, 32'h0, 32'h0000_1044, 1'b1, 1'b0}, // R2 R3 forward
        '{3'd1, 32'h0000_1000, 32'd5, 32'd6, 16'h0010, 26'h0, 32'h0, 32'h0000_1004, 1'b0, 1'b0}, // R2 not taken
        '{3'd2, 32'h0000_1000, 32'd5, 32'd6, 16'hFFFC, 26'h0, 32'h0, 32'h0000_0FF4, 1'b1, 1'b0}, // R3 backward
        '{3'd2, 32'h0000_1000, 32'd7, 32'd7, 16'hFFFC, 26'h0, 32'h0, 32'h0000_1004, 1'b0, 1'b0}, // R2 bne equal
        '{3'd1, 32'h0010_0000, 32'd1, 32'd1, 16'h7FFF, 26'h0, 32'h0, 32'h0012_0000, 1'b1, 1'b0}, // R3 max fwd
        '{3'd1, 32'h0010_0000, 32'd1, 32'd1, 16'h8000, 26'h0, 32'h0, 32'h000E_0004, 1'b1, 1'b0}, // R3 max back
        '{3'd1, 32'hFFFF_FFF0, 32'd3, 32'd3, 16'h0004, 26'h0, 32'h0, 32'h0000_0004, 1'b1, 1'b0}, // R3 wrap
        '{3'd1, 32'h0000_2000, 32'h8000_0000, 32'd0, 16'h0004, 26'h0, 32'h0, 32'h0000_2004, 1'b0, 1'b0}, // R2 msb
        '{3'd3, 32'h0000_0040, 32'd0, 32'd0, 16'h0, 26'd2500, 32'h0, 32'h0000_2710, 1'b1, 1'b0}, // R4 2500
        '{3'd3, 32'h2FFF_FFFC, 32'd0, 32'd0, 16'h0, 26'h10, 32'h0, 32'h3000_0040, 1'b1, 1'b0}, // R4 region step
        '{3'd3, 32'h4FFF_FFF8, 32'd0, 32'd0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h4FFF_FFFC, 1'b1, 1'b0}, // R4 top
        '{3'd4, 32'h0040_0020, 32'd0, 32'd0, 16'h0, 26'h010_0000, 32'h0, 32'h0040_0000, 1'b1, 1'b1}, // R7 call
        '{3'd5, 32'h0000_0100, 32'd0, 32'd0, 16'h0, 26'h0, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0}, // R5 R6
        '{3'd6, 32'h0000_0008, 32'd0, 32'd0, 16'h0, 26'h0, 32'h0, 32'h0000_000C, 1'b0, 1'b0}  // R1 spare code
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ctl_class = v.cls; cur_pc = v.pc; cmp_a = v.a; cmp_b = v.b;
        br_offset = v.ofs; jmp_field = v.fld; jr_value = v.jr;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(next_pc == 32'h0, "R9 reset pc", next_pc, 32'h0);
        chk(!taken && !link_we && link_value == 0, "R9 reset flags", {taken, link_we}, 32'h0);
        rst_n = 1'b1;

        // R8: drive after a falling edge, one rising edge, sample at next falling edge
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            chk(next_pc == VECS[i].exp_pc, $sformatf("R3/R4 vec%0d next_pc", i), next_pc, VECS[i].exp_pc);
            chk(taken == VECS[i].exp_tk, $sformatf("R6 vec%0d taken", i), taken, VECS[i].exp_tk);
            chk(link_we == VECS[i].exp_lk, $sformatf("R7 vec%0d link_we", i), link_we, VECS[i].exp_lk);
            if (VECS[i].exp_lk)
                chk(link_value == VECS[i].pc + 32'd4, "R7 link value", link_value, VECS[i].pc + 32'd4);
            chk(link_reg == 5'd31, "R7 link_reg", link_reg, 32'd31);
        end

        // R8: result is not visible before the rising edge
        drive('{3'd5, 32'h0, 32'h0, 32'h0, 16'h0, 26'h0, 32'hCAFE_0000, 32'h0, 1'b0, 1'b0});
        @(posedge clk);
        #1;
        drive('{3'd0, 32'h0000_0500, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b0, 1'b0});
        chk(next_pc == 32'hCAFE_0000, "R8 after one edge", next_pc, 32'hCAFE_0000);
        @(negedge clk);
        chk(next_pc == 32'hCAFE_0000, "R8 held until next edge", next_pc, 32'hCAFE_0000);
        @(negedge clk);
        chk(next_pc == 32'h0000_0504, "R8 next sample", next_pc, 32'h0000_0504);

        // R7: call then sequential drops the link request
        drive('{3'd4, 32'h1000_0000, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b0, 1'b0});
        @(negedge clk);
        chk(link_we && link_value == 32'h1000_0004, "R7 call link", link_value, 32'h1000_0004);
        chk(next_pc == 32'h1000_0000, "R4 call target", next_pc, 32'h1000_0000);
        drive('{3'd0, 32'h1000_0000, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b0, 1'b0});
        @(negedge clk);
        chk(!link_we, "R7 no link after seq", link_we, 32'h0);

        // R9: reset in mid-run
        drive('{3'd3, 32'h0, 32'h0, 32'h0, 16'h0, 26'h5, 32'h0, 32'h0, 1'b0, 1'b0});
        rst_n = 1'b0;
        @(negedge clk);
        chk(next_pc == 32'h0 && !taken, "R9 mid-run reset", next_pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(next_pc == 32'h0000_0014 && taken, "R4 after reset", next_pc, 32'h0000_0014);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule